// File: doc/BRIEF.md
# Card Bus Clock and Power Controller

This block produces the clock for a removable card bus from the kernel clock. It also steps the card interface through its power phases. A programmable divider either passes the kernel clock through unchanged or divides it by an even ratio with equal high and low times. The card clock is held low after reset and whenever the interface is not fully powered. It is also held low while software has the clock disabled, while the data path asks for a flow-control pause, and (when power saving is on) once the command and data state machines have both been idle for a fixed number of kernel cycles.

The card bus output enable and the three line-direction controls stay inactive until the interface reaches the powered-on phase. The three direction controls cover the command line, data line 0 and data lines 1 to 3. Clock stops take effect only while the divided clock is low, so every high phase on the card clock runs for its full length.

Top module: `cardclk_ctrl`

## Requirements
- R1: The 2-bit `pwr_mode` input is decoded as 00 = off, 10 = ramp-up and 11 = on. The reserved value 01 behaves exactly like off.
- R2: `bus_oe` is high only in the on phase, one kernel cycle after `pwr_mode` = 11 is sampled. It is low in every other phase.
- R3: While `rst` is high and directly after it, `card_clk`, `bus_oe`, `cmd_dir`, `d0_dir` and `d123_dir` are all low.
- R4: In the off, reserved and ramp-up phases, `card_clk` stays low. When the phase leaves on, the clock is forced low within two kernel cycles, in either divider mode.
- R5: With `psave_en` = 1, once `cmd_idle` and `dat_idle` are both sampled high for 8 consecutive kernel cycles, the card clock stops. In pass-through mode, the last high phase is the one following the 9th such edge. With `psave_en` = 0, idleness never stops the clock.
- R6: The idle count restarts from zero whenever either idle flag drops. The clock resumes within three kernel cycles of activity in pass-through mode, and on the next divided edge in divider mode.
- R7: While `flow_stop` is high, the card clock stays low; it resumes after `flow_stop` is released.
- R8: `cmd_dir` is high (host drives) only in the on phase while `cmd_idle` is low. `d0_dir` and `d123_dir` are high only in the on phase while `dat_idle` is low. All three are registered one cycle.
- R9: `div_val` = 0 selects pass-through: the card clock equals the kernel clock while enabled, and is low otherwise.
- R10: `div_val` = N (N > 0) gives a card clock period of 2N kernel cycles, with N cycles high and N cycles low.
- R11: In divider mode, a stop request never shortens a high phase; the high phase in progress lasts its full N cycles.
- R12: `clk_en` = 0 holds the card clock low; setting it back to 1 restarts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_mode | input | 2 | Power phase request (00 off, 10 ramp-up, 11 on, 01 reserved) |
| div_val | input | DIV_W | Divider value; 0 means pass-through |
| clk_en | input | 1 | Card clock enable |
| psave_en | input | 1 | Power-save clock stop enable |
| flow_stop | input | 1 | Flow-control request to pause the card clock |
| cmd_idle | input | 1 | Command/response state machine is idle |
| dat_idle | input | 1 | Data path state machine is idle |
| card_clk | output | 1 | Card bus clock |
| bus_oe | output | 1 | Output enable for card bus signals |
| cmd_dir | output | 1 | Command line direction, 1 = host drives |
| d0_dir | output | 1 | Data line 0 direction, 1 = host drives |
| d123_dir | output | 1 | Data lines 1 to 3 direction, 1 = host drives |

## Verification
The divider is swept over the ratios 1, 2, 3, 4 and 6. For each ratio the bench counts rising edges and high samples in a fixed window. This separates a correct 2N period from an N period or an off-by-one terminal count, and it catches an unbalanced duty cycle. The power-save stop is probed cycle by cycle in pass-through mode, so a counter that stops one cycle early or late shows up. An interrupted idle stretch checks that the count restarts. A flow stop issued at the start of a high phase, followed by a count of the remaining high samples, shows whether the gate truncates a pulse. Stepping through all four phase codes separates reserved and ramp-up from on, for both the output enable and the clock.

// File: rtl/cbclk_pkg.sv
package cbclk_pkg;

    typedef enum logic [1:0] {
        PH_OFF  = 2'b00,
        PH_RSVD = 2'b01,
        PH_UP   = 2'b10,
        PH_ON   = 2'b11
    } phase_e;

    typedef struct packed {
        logic cmd;
        logic d0;
        logic d123;
    } dir_t;

    localparam dir_t DIR_ALL_IN = '{cmd: 1'b0, d0: 1'b0, d123: 1'b0};

    // Reserved code folds onto the off phase.
    function automatic phase_e decode_phase(input logic [1:0] code);
        phase_e ph;
        case (code)
            2'b11:   ph = PH_ON;
            2'b10:   ph = PH_UP;
            default: ph = PH_OFF;
        endcase
        return ph;
    endfunction

    function automatic logic phase_is_on(input phase_e ph);
        return ph == PH_ON;
    endfunction

endpackage

// File: rtl/cbclk_power.sv
module cbclk_power
    import cbclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] pwr_mode,
    input  logic       cmd_idle,
    input  logic       dat_idle,
    output logic       phase_on,
    output logic       bus_oe,
    output dir_t       dirs
);
    phase_e phase;
    dir_t   dirs_d;

    assign phase    = decode_phase(pwr_mode);
    assign phase_on = phase_is_on(phase);

    always_comb begin
        dirs_d = DIR_ALL_IN;
        if (phase_on) begin
            dirs_d.cmd  = ~cmd_idle;
            dirs_d.d0   = ~dat_idle;
            dirs_d.d123 = ~dat_idle;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_oe <= 1'b0;
            dirs   <= DIR_ALL_IN;
        end else begin
            bus_oe <= phase_on;
            dirs   <= dirs_d;
        end
    end
endmodule

// File: rtl/cbclk_idle.sv
module cbclk_idle #(
    parameter int IDLE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_idle,
    input  logic dat_idle,
    output logic expired
);
    localparam int CW = $clog2(IDLE_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES);

    logic [CW-1:0] cnt_q;
    logic          both_idle;

    assign both_idle = cmd_idle & dat_idle;
    assign expired   = (cnt_q == LIMIT);

    always_ff @(posedge clk) begin
        if (rst || !both_idle) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cbclk_divider.sv
module cbclk_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             phase_on,
    input  logic [DIV_W-1:0] div_val,
    input  logic             run,
    output logic             card_clk,
    output logic             gate_n,
    output logic             div_q
);
    logic [DIV_W-1:0] cnt_q;
    logic             bypass;
    logic             terminal;

    assign bypass   = (div_val == '0);
    assign terminal = (cnt_q >= div_val - 1'b1);

    // Divided path: a rise is only allowed when running, a fall always completes.
    always_ff @(posedge clk) begin
        if (rst || !phase_on || bypass) begin
            cnt_q <= '0;
            div_q <= 1'b0;
        end else if (terminal) begin
            cnt_q <= '0;
            if (div_q)
                div_q <= 1'b0;
            else if (run)
                div_q <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Pass-through gate changes only while the kernel clock is low.
    always_ff @(negedge clk) begin
        if (rst)
            gate_n <= 1'b0;
        else
            gate_n <= run & bypass & phase_on;
    end

    assign card_clk = bypass ? (clk & gate_n) : div_q;
endmodule

// File: rtl/cardclk_ctrl.sv
module cardclk_ctrl
    import cbclk_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int IDLE_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       pwr_mode,
    input  logic [DIV_W-1:0] div_val,
    input  logic             clk_en,
    input  logic             psave_en,
    input  logic             flow_stop,
    input  logic             cmd_idle,
    input  logic             dat_idle,
    output logic             card_clk,
    output logic             bus_oe,
    output logic             cmd_dir,
    output logic             d0_dir,
    output logic             d123_dir
);
    logic phase_on;
    logic expired;
    logic run_q;
    logic gate_n;
    logic div_q;
    dir_t dirs;

    cbclk_power u_power (
        .clk      (clk),
        .rst      (rst),
        .pwr_mode (pwr_mode),
        .cmd_idle (cmd_idle),
        .dat_idle (dat_idle),
        .phase_on (phase_on),
        .bus_oe   (bus_oe),
        .dirs     (dirs)
    );

    cbclk_idle #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
        .clk      (clk),
        .rst      (rst),
        .cmd_idle (cmd_idle),
        .dat_idle (dat_idle),
        .expired  (expired)
    );

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= 1'b0;
        else
            run_q <= phase_on & clk_en & ~flow_stop & ~(psave_en & expired);
    end

    cbclk_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .phase_on (phase_on),
        .div_val  (div_val),
        .run      (run_q),
        .card_clk (card_clk),
        .gate_n   (gate_n),
        .div_q    (div_q)
    );

    assign cmd_dir  = dirs.cmd;
    assign d0_dir   = dirs.d0;
    assign d123_dir = dirs.d123;
endmodule

// File: rtl/cardclk_ctrl_chk.sv
module cardclk_ctrl_chk #(
    parameter int DIV_W       = 8,
    parameter int IDLE_CYCLES = 8
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] pwr_mode,
    input logic       flow_stop,
    input logic       psave_en,
    input logic       cmd_idle,
    input logic       dat_idle,
    input logic       bus_oe,
    input logic       cmd_dir,
    input logic       run_q,
    input logic       gate_n,
    input logic       div_q
);
    localparam int CW = $clog2(IDLE_CYCLES + 2);
    localparam logic [CW-1:0] STOP_AT = CW'(IDLE_CYCLES + 1);

    logic [CW-1:0] idle_seen;

    always_ff @(posedge clk) begin
        if (rst || !(psave_en && cmd_idle && dat_idle))
            idle_seen <= '0;
        else if (idle_seen != STOP_AT)
            idle_seen <= idle_seen + 1'b1;
    end

    AST_OE_NEEDS_ON: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> $past(pwr_mode) == 2'b11); // R2

    AST_GATE_OFF_UNPOWERED: assert property (@(posedge clk) disable iff (rst)
        $past(pwr_mode) != 2'b11 |-> !gate_n && !div_q); // R4

    AST_PSAVE_STOPS: assert property (@(posedge clk) disable iff (rst)
        idle_seen == STOP_AT |-> !run_q); // R5

    AST_FLOW_HOLDS: assert property (@(posedge clk) disable iff (rst)
        $past(flow_stop) |-> !run_q); // R7

    AST_CMD_DIR_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        cmd_dir |-> bus_oe && !$past(cmd_idle)); // R8

    AST_RISE_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        $rose(div_q) |-> $past(run_q)); // R11
endmodule

bind cardclk_ctrl cardclk_ctrl_chk #(.DIV_W(DIV_W), .IDLE_CYCLES(IDLE_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwr_mode  (pwr_mode),
    .flow_stop (flow_stop),
    .psave_en  (psave_en),
    .cmd_idle  (cmd_idle),
    .dat_idle  (dat_idle),
    .bus_oe    (bus_oe),
    .cmd_dir   (cmd_dir),
    .run_q     (run_q),
    .gate_n    (gate_n),
    .div_q     (div_q)
);

// File: tb/test_cardclk_ctrl.sv
`timescale 1ns/1ps
module test_cardclk_ctrl;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic [1:0]       pwr_mode;
    logic [DIV_W-1:0] div_val;
    logic             clk_en, psave_en, flow_stop, cmd_idle, dat_idle;
    logic             card_clk, bus_oe, cmd_dir, d0_dir, d123_dir;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    cardclk_ctrl #(.DIV_W(DIV_W), .IDLE_CYCLES(8)) i_cardclk_ctrl (
        .clk(clk), .rst(rst), .pwr_mode(pwr_mode), .div_val(div_val),
        .clk_en(clk_en), .psave_en(psave_en), .flow_stop(flow_stop),
        .cmd_idle(cmd_idle), .dat_idle(dat_idle), .card_clk(card_clk),
        .bus_oe(bus_oe), .cmd_dir(cmd_dir), .d0_dir(d0_dir), .d123_dir(d123_dir)
    );

    // {divider value, expected rising edges in 24 samples}
    localparam logic [15:0] DIV_VEC [5] = '{
        {8'd1, 8'd12}, {8'd2, 8'd6}, {8'd3, 8'd4}, {8'd4, 8'd3}, {8'd6, 8'd2}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Advance to 5 ns after the next rising kernel edge (kernel clock high).
    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #5;
        end
    endtask

    task automatic wait_rise(output bit found);
        logic prev;
        found = 1'b0;
        prev = card_clk;
        for (int i = 0; i < 40 && !found; i++) begin
            step();
            if (card_clk && !prev) found = 1'b1;
            prev = card_clk;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit found;
        int rises, highs;
        logic prev;
        rst = 1'b1; pwr_mode = 2'b00; div_val = '0; clk_en = 1'b1;
        psave_en = 1'b0; flow_stop = 1'b0; cmd_idle = 1'b1; dat_idle = 1'b1;
        step(3);
        check("R3 clk in reset", card_clk, 0);
        check("R3 oe in reset", bus_oe, 0);
        check("R3 dirs in reset", {cmd_dir, d0_dir, d123_dir}, 0);
        rst = 1'b0;
        step(2);
        check("R3 clk after reset", card_clk, 0);

        // Phase codes other than on keep everything inactive.
        pwr_mode = 2'b01; cmd_idle = 1'b0;
        step(3);
        check("R1 reserved oe", bus_oe, 0);
        check("R1 reserved clk", card_clk, 0);
        check("R8 dir off when unpowered", cmd_dir, 0);
        pwr_mode = 2'b10;
        step(3);
        check("R4 ramp-up clk", card_clk, 0);
        check("R2 ramp-up oe", bus_oe, 0);

        pwr_mode = 2'b11;
        step();
        check("R2 oe one cycle after on", bus_oe, 1);
        step(2);
        check("R9 pass-through high", card_clk, 1);
        #10;
        check("R9 pass-through low", card_clk, 0);
        step();
        check("R8 cmd driven", cmd_dir, 1);
        check("R8 data lines in", {d0_dir, d123_dir}, 0);
        dat_idle = 1'b0;
        step();
        check("R8 data lines driven", {d0_dir, d123_dir}, 3);
        cmd_idle = 1'b1;
        step();
        check("R8 cmd released", cmd_dir, 0);

        clk_en = 1'b0;
        step(3);
        check("R12 disabled clk low", card_clk, 0);
        clk_en = 1'b1;
        step(3);
        check("R12 re-enabled", card_clk, 1);

        // Power save off: idleness does not stop the clock.
        dat_idle = 1'b1;
        step(20);
        check("R5 psave off keeps running", card_clk, 1);

        // Power save on with a fresh idle stretch.
        cmd_idle = 1'b0; psave_en = 1'b1;
        step(2);
        cmd_idle = 1'b1;
        for (int j = 1; j <= 11; j++) begin
            step();
            if (j == 9 || j == 10 || j == 11)
                check($sformatf("R5 psave cycle %0d", j), card_clk, (j <= 9) ? 1 : 0);
        end
        cmd_idle = 1'b0;
        step(3);
        check("R6 resume after activity", card_clk, 1);

        // Interrupted stretch restarts the count.
        cmd_idle = 1'b1;
        step(5);
        cmd_idle = 1'b0;
        step();
        cmd_idle = 1'b1;
        step(9);
        check("R6 count restarted", card_clk, 1);
        step();
        check("R6 stop after full stretch", card_clk, 0);
        cmd_idle = 1'b0; psave_en = 1'b0;
        step(3);

        // Divider ratio sweep.
        foreach (DIV_VEC[k]) begin
            div_val = DIV_VEC[k][15:8];
            step(4);
            wait_rise(found);
            rises = 0; highs = 1; prev = card_clk;
            for (int s = 1; s <= 24; s++) begin
                step();
                if (card_clk && !prev) rises++;
                if (card_clk && s < 24) highs++;
                prev = card_clk;
            end
            check($sformatf("R10 rises div=%0d", div_val), rises, int'(DIV_VEC[k][7:0]));
            check($sformatf("R10 duty div=%0d", div_val), highs, 12);
        end

        // Flow stop at the start of a high phase does not shorten it.
        div_val = 8'd4;
        step(2);
        wait_rise(found);
        flow_stop = 1'b1;
        highs = 1;
        for (int s = 0; s < 16; s++) begin
            step();
            if (card_clk) highs++;
        end
        check("R11 full high phase kept", highs, 4);
        check("R7 held low under flow stop", card_clk, 0);
        flow_stop = 1'b0;
        wait_rise(found);
        check("R7 resumes after release", found, 1);

        // Dropping power forces the divided clock low.
        pwr_mode = 2'b10;
        step(2);
        highs = 0;
        for (int s = 0; s < 10; s++) begin
            step();
            if (card_clk) highs++;
        end
        check("R4 divided clk low after power drop", highs, 0);
        check("R2 oe dropped", bus_oe, 0);
        pwr_mode = 2'b00;
        step(2);
        check("R1 off oe", bus_oe, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule